// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Mode Decoding

This block is a clocked, synthesizable model of a byte-wide memory whose cells start erased at one. Programming can only pull individual bits to zero. Five control inputs select what the memory does:

- an active-low chip select;
- an active-low output gate;
- an active-low write strobe;
- a flag meaning the programming supply is raised;
- a flag meaning the identity pin is raised to its high voltage.

From these inputs the block decodes standby, normal read, program, program-verify, inhibit and identity behaviour. The data output has a separate drive-enable that stands in for the tri-state pins. A synchronous erase input returns the whole array to all ones, standing in for ultraviolet exposure.

The address width is a parameter. Setting `ADDR_W` to 13 gives the full 8K x 8 array. The default is 11, which keeps the elaborated array to 2K words. Identity mode ignores the array and returns two fixed code bytes, selected by address bit 0. A programming write is accepted only if the program conditions hold for every clock the strobe is low. It is committed on the first clock that sees the strobe high again.

Top module: `otp_mode_mem`

## Requirements
- R1: A clock with `erase` high sets every array byte to all ones (0xFF for 8-bit data).
- R2: With `ce_n`, `oe_n` low and both `vpp_hi` and `id_hv` low, `dout_en` is 1 and `dout` equals the addressed array byte, independent of `pgm_n`.
- R3: With `ce_n` high, `dout_en` is 0 whatever the other inputs are.
- R4: With `oe_n` and `pgm_n` both high, `dout_en` is 0. In general `dout_en` = !ce_n & !oe_n & (id_hv | !vpp_hi | pgm_n).
- R5: A write pulse stores into the addressed byte. A write pulse is `pgm_n` low for one or more clocks, with `vpp_hi`=1, `ce_n`=0 and `oe_n`=1 at every one of them. The address and data used are those sampled at the last low clock. The new value is visible on the clock where `pgm_n` is first sampled high.
- R6: A write stores the AND of the old byte and `din`, so bits can never go from 0 back to 1 except through erase.
- R7: The array stays unchanged in three cases. The first is `ce_n` held high during a strobe pulse. The second is `pgm_n` held high while the other program conditions are true. The third is a program condition dropping at any clock of the low phase.
- R8: With `vpp_hi`=1, `id_hv`=0, `ce_n`=0, `oe_n`=0 and `pgm_n`=1 (verify), `dout_en` is 1 and `dout` equals the addressed array byte.
- R9: With `id_hv`=1, `ce_n`=0 and `oe_n`=0, `dout_en` is 1 and `dout` is `MFR_ID` (default 0x29) when address bit 0 is 0, and `DEV_ID` (default 0x02) when it is 1. The result does not depend on array contents or erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset of the strobe tracking |
| erase | input | 1 | Synchronous whole-array erase to all ones |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| pgm_n | input | 1 | Active-low write strobe |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identity pin at high voltage |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Data to program |
| dout | output | DATA_W | Read, verify or identity data (zero when not driven) |
| dout_en | output | 1 | Output drive enable; 0 means high impedance |

## Verification
The data path is tried with three kinds of data, each across every address of a small array. Fresh erase reads all ones. A first programming pass uses an address-derived pattern and shows the write lands only at its own address. A second pass uses the complemented address, and the read-back must equal the AND of both patterns, which separates clear-only programming from plain overwrite. Every combination of the five control inputs is then applied and compared against the drive-enable formula, which separates standby, output gating, verify and identity decoding. Aborted and inhibited strobe pulses show whether write qualification covers the entire low phase.

// File: rtl/otp_mode_mem.sv
module otp_mode_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] MFR_ID = 8'h29,
  parameter logic [DATA_W-1:0] DEV_ID = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              erase,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pgm_n,
  input  logic              vpp_hi,
  input  logic              id_hv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];
  logic              pgm_q, armed;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  wire prog_ok = vpp_hi & ~ce_n & oe_n;
  wire commit  = pgm_n & armed;
  wire id_mode = id_hv & ~ce_n & ~oe_n;

  assign dout_en = ~ce_n & ~oe_n & (id_hv | ~vpp_hi | pgm_n);
  assign dout    = !dout_en ? '0 : id_mode ? (addr[0] ? DEV_ID : MFR_ID) : cells[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pgm_q <= 1'b1;
      armed <= 1'b0;
      waddr <= '0;
      wdata <= '0;
    end else begin
      pgm_q <= pgm_n;
      if (!pgm_n) begin
        armed <= prog_ok & (pgm_q | armed);
        waddr <= addr;
        wdata <= din;
      end else begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (commit) begin
      cells[waddr] <= cells[waddr] & wdata;
    end
  end

  p_standby_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dout_en);
  p_gate_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_n && pgm_n) |-> !dout_en);
  p_arm_qualified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> $past(prog_ok && !pgm_n));
  p_clear_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !erase) |=> ((cells[$past(waddr)] & ~$past(cells[waddr])) == '0));
  p_erase_ones_r1: assert property (@(posedge clk) disable iff (!rst_n)
    erase |=> (cells[$past(addr)] == '1));
  p_id_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    id_mode |-> dout_en);
endmodule

// File: tb/sim_otp_mode_mem.sv
module sim_otp_mode_mem;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N = 1 << AW;

  logic clk = 0, rst_n = 0, erase = 0;
  logic ce_n = 1, oe_n = 1, pgm_n = 1, vpp_hi = 0, id_hv = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_en;
  int checks = 0, errors = 0;
  logic [DW-1:0] model [N];

  otp_mode_mem #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .erase(erase), .ce_n(ce_n), .oe_n(oe_n),
    .pgm_n(pgm_n), .vpp_hi(vpp_hi), .id_hv(id_hv), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 37 + 5);
  endfunction

  task automatic rd(input int a, input logic [DW-1:0] exp, input string req);
    ce_n = 0; oe_n = 0; pgm_n = 1; id_hv = 0; addr = AW'(a); #1;
    chk(dout_en, 1, req);
    chk(dout, exp, req);
  endtask

  task automatic prog(input int a, input logic [DW-1:0] d);
    vpp_hi = 1; ce_n = 0; oe_n = 1; id_hv = 0; addr = AW'(a); din = d;
    pgm_n = 0; step(); step();
    pgm_n = 1; step();
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk(dout_en, 0, "R3 reset");
    // R1: erase, then read all
    erase = 1; step(); erase = 0;
    for (int a = 0; a < N; a++) begin rd(a, 8'hFF, "R1"); model[a] = 8'hFF; end
    // R2 read independent of pgm_n
    addr = 3; pgm_n = 0; ce_n = 0; oe_n = 0; vpp_hi = 0; #1;
    chk(dout_en, 1, "R2 pgm_low"); chk(dout, 8'hFF, "R2 pgm_low");
    pgm_n = 1; step();
    // R5 first pass
    for (int a = 0; a < N; a++) begin prog(a, pat(a)); model[a] &= pat(a); end
    vpp_hi = 0;
    for (int a = 0; a < N; a++) rd(a, model[a], "R5");
    // R6 second pass, clear-only
    for (int a = 0; a < N; a++) begin prog(a, ~DW'(a)); model[a] &= ~DW'(a); end
    vpp_hi = 0;
    for (int a = 0; a < N; a++) rd(a, model[a], "R6");
    // R8 verify
    vpp_hi = 1;
    for (int a = 0; a < N; a++) begin
      ce_n = 0; oe_n = 0; pgm_n = 1; addr = AW'(a); #1;
      chk(dout_en, 1, "R8"); chk(dout, model[a], "R8");
    end
    // R7 inhibit: ce_n high during pulse
    vpp_hi = 1; ce_n = 1; oe_n = 1; addr = 5; din = 8'h00; pgm_n = 0; step(); step();
    pgm_n = 1; step();
    vpp_hi = 0; rd(5, model[5], "R7 ce_high");
    // R7 pgm_n held high
    vpp_hi = 1; ce_n = 0; oe_n = 1; addr = 6; din = 8'h00; step(); step(); step();
    vpp_hi = 0; rd(6, model[6], "R7 pgm_high");
    // R7 abort mid-pulse
    vpp_hi = 1; ce_n = 0; oe_n = 1; addr = 7; din = 8'h00; pgm_n = 0; step();
    ce_n = 1; step(); ce_n = 0; step(); pgm_n = 1; step();
    vpp_hi = 0; rd(7, model[7], "R7 abort");
    vpp_hi = 1; ce_n = 0; oe_n = 1; addr = 8; din = 8'h00; pgm_n = 0; step();
    vpp_hi = 0; step(); pgm_n = 1; step();
    rd(8, model[8], "R7 vpp_drop");
    // R3/R4/R9 decode sweep
    for (int c = 0; c < 32; c++) begin
      for (int a = 0; a < 2; a++) begin
        logic en;
        ce_n = c[0]; oe_n = c[1]; pgm_n = c[2]; vpp_hi = c[3]; id_hv = c[4];
        addr = AW'(a + 10); #1;
        en = !c[0] && !c[1] && (c[4] || !c[3] || c[2]);
        chk(dout_en, en, c[0] ? "R3" : "R4");
        if (en) chk(dout, c[4] ? (a[0] ? 8'h02 : 8'h29) : model[a + 10], c[4] ? "R9" : "R2/R8");
      end
    end
    pgm_n = 1; vpp_hi = 0; id_hv = 0; ce_n = 1; oe_n = 1; step();
    // R1 re-erase, R9 codes unchanged
    erase = 1; step(); erase = 0;
    for (int a = 0; a < N; a++) rd(a, 8'hFF, "R1 again");
    id_hv = 1; ce_n = 0; oe_n = 0;
    addr = 6'h3E; #1; chk(dout, 8'h29, "R9 mfr");
    addr = 6'h21; #1; chk(dout, 8'h02, "R9 dev");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule